// File: doc/BRIEF.md
# Burst Crossbar with Window Decode and Per-Target Round-Robin

This block joins a set of request-issuing initiators to a set of response-giving targets over a burst request/response bus. Every request beat carries an address; the address is compared with a programmable window per target. When several windows cover the same address, the window with the lowest index wins. A request that no window covers goes to an internal error responder and never reaches a target.

Each target has its own round-robin arbiter. An arbiter chooses one contending initiator and keeps that choice for the whole transaction: every request beat up to the end-of-burst beat, then every response beat up to the final one. Responses go back along the held grant. Because the arbiters work independently, all targets can carry bursts from different initiators in the same cycle.

Windows are loaded through a single-cycle write port. The port sets the base, the limit and the enable of one window at a time. Each initiator keeps at most one transaction open, and initiators accept response beats without stalling.

Top module: `burst_xbar`

## Requirements
- R1: After reset no target is granted, every window is disabled, `i_ready`, `i_rvalid` and `t_valid` are all 0, and any request is answered by the error responder.
- R2: Window j is enabled and matches an address when base ≤ addr ≤ limit, with both bounds inclusive. Window j selects target j. When windows overlap, the matching window with the lowest index is used.
- R3: When `cfg_we` is high at a rising clock edge, the base, limit and enable of window `cfg_idx` are replaced. A window whose enable is written 0 stops matching from the next cycle.
- R4: A grant to a target starts at the cycle an initiator is picked. It stays with that initiator until the cycle the target returns a response beat with `t_rlast` = 1. A target never receives beats of two initiators within one transaction.
- R5: When a grant ends, the target's pointer becomes the served initiator's index plus one, modulo the number of initiators. The next grant goes to the first requesting initiator at or after the pointer, in ascending order with wrap.
- R6: Targets arbitrate independently. All targets can carry request beats from different initiators in the same cycle.
- R7: A beat whose address matches no enabled window is accepted at once (`i_ready` = 1) and never appears on any target. In the cycle after its end-of-burst beat is accepted, the initiator gets exactly one response beat with `i_rerr` = 1, `i_rlast` = 1 and data 0.
- R8: A target's response beats go combinationally to the initiator that holds its grant. `i_rdata` equals `t_rdata`, `i_rlast` equals `t_rlast`, and `i_rerr` = 0.
- R9: The granted initiator's beat appears combinationally on its target's `t_valid`, `t_addr`, `t_wdata` and `t_last`, in the order it was issued. Its `i_ready` equals that target's `t_ready`. An initiator without a grant sees `i_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Window write strobe |
| cfg_idx | input | TW | Window index to write |
| cfg_base | input | ADDR_W | Lowest address of the window |
| cfg_limit | input | ADDR_W | Highest address of the window |
| cfg_en | input | 1 | Window enable |
| i_valid | input | N_INI | Request beat valid per initiator |
| i_addr | input | N_INI*ADDR_W | Request address per initiator |
| i_wdata | input | N_INI*DATA_W | Request data per initiator |
| i_last | input | N_INI | End-of-burst beat per initiator |
| i_ready | output | N_INI | Request beat accepted per initiator |
| i_rvalid | output | N_INI | Response beat valid per initiator |
| i_rdata | output | N_INI*DATA_W | Response data per initiator |
| i_rlast | output | N_INI | Final response beat per initiator |
| i_rerr | output | N_INI | Decode-error response per initiator |
| t_valid | output | N_TGT | Request beat valid per target |
| t_addr | output | N_TGT*ADDR_W | Request address per target |
| t_wdata | output | N_TGT*DATA_W | Request data per target |
| t_last | output | N_TGT | End-of-burst beat per target |
| t_ready | input | N_TGT | Target accepts request beat |
| t_rvalid | input | N_TGT | Response beat valid per target |
| t_rdata | input | N_TGT*DATA_W | Response data per target |
| t_rlast | input | N_TGT | Final response beat per target |

## Verification
Two situations are provoked on purpose. In the first, all eight targets grant in one cycle: every initiator starts a burst at the same clock toward a different target, and the bench counts cycles in which all eight `t_valid` are high. In the second, the error responder accepts an unmatched burst in the same cycles that a real target accepts another initiator's burst. That case is judged by comparing the number of beats seen on the targets against the burst length of the matched initiator only, and by checking both responses. Round-robin order under contention is compared against an order the bench derives from its own pointer model.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int XB_DEF_PORTS  = 8;
  localparam int XB_DEF_ADDR_W = 32;
  localparam int XB_DEF_DATA_W = 32;

  // next index after cur, wrapping at n
  function automatic int rr_after(input int cur, input int n);
    return (cur + 1 >= n) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/xbar_win_table.sv
module xbar_win_table #(
  parameter int N_INI  = 8,
  parameter int N_TGT  = 8,
  parameter int ADDR_W = 32,
  parameter int TW     = 3
)(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [TW-1:0]               cfg_idx,
  input  logic [ADDR_W-1:0]           cfg_base,
  input  logic [ADDR_W-1:0]           cfg_limit,
  input  logic                        cfg_en,
  input  logic [N_INI*ADDR_W-1:0]     ini_addr,
  output logic [N_INI-1:0]            hit,
  output logic [N_INI-1:0][TW-1:0]    sel
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N_TGT-1:0][ADDR_W-1:0] base_q;
  logic [N_TGT-1:0][ADDR_W-1:0] lim_q;
  logic [N_TGT-1:0]             en_q;

  function automatic logic win_hit(input logic [ADDR_W-1:0] a,
                                   input logic [ADDR_W-1:0] lo,
                                   input logic [ADDR_W-1:0] hi,
                                   input logic              on);
    return on && (a >= lo) && (a <= hi);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      lim_q  <= '0;
      en_q   <= '0;
    end else if (cfg_we && (int'(cfg_idx) < N_TGT)) begin
      base_q[cfg_idx] <= cfg_base;
      lim_q[cfg_idx]  <= cfg_limit;
      en_q[cfg_idx]   <= cfg_en;
    end
  end

  for (genvar gi = 0; gi < N_INI; gi++) begin : g_dec
    logic          h;
    logic [TW-1:0] s;
    always_comb begin
      h = 1'b0;
      s = '0;
      // scan downward so the lowest matching index is kept last
      for (int j = N_TGT - 1; j >= 0; j--) begin
        if (win_hit(ini_addr[gi*ADDR_W +: ADDR_W], base_q[j], lim_q[j], en_q[j])) begin
          h = 1'b1;
          s = TW'(j);
        end
      end
    end
    assign hit[gi] = h;
    assign sel[gi] = s;
  end
endmodule

// File: rtl/xbar_tgt_arb.sv
module xbar_tgt_arb import xbar_pkg::*; #(
  parameter int N_INI = 8,
  parameter int IW    = 3
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_INI-1:0] req,
  input  logic             done,
  output logic             hold,
  output logic             act,
  output logic [IW-1:0]    owner
);
  timeunit 1ns;
  timeprecision 1ps;

  function automatic logic [IW-1:0] rr_pick(input logic [N_INI-1:0] r,
                                            input logic [IW-1:0]    start);
    logic [IW-1:0] pick;
    logic          found;
    int            idx;
    pick  = start;
    found = 1'b0;
    for (int k = 0; k < N_INI; k++) begin
      idx = int'(start) + k;
      if (idx >= N_INI) idx = idx - N_INI;
      if (!found && r[idx]) begin
        found = 1'b1;
        pick  = IW'(idx);
      end
    end
    return pick;
  endfunction

  logic          hold_q;
  logic [IW-1:0] own_q;
  logic [IW-1:0] ptr_q;
  logic [IW-1:0] pick_w;
  logic          any_w;
  logic          evt_grant;
  logic          evt_release;

  assign pick_w      = rr_pick(req, ptr_q);
  assign any_w       = |req;
  assign evt_grant   = !hold_q && any_w;
  assign evt_release = hold_q && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      own_q  <= '0;
      ptr_q  <= '0;
    end else if (evt_grant) begin
      hold_q <= 1'b1;
      own_q  <= pick_w;
    end else if (evt_release) begin
      hold_q <= 1'b0;
      ptr_q  <= IW'(rr_after(int'(own_q), N_INI));
    end
  end

  assign hold  = hold_q;
  assign act   = hold_q || any_w;
  assign owner = hold_q ? own_q : pick_w;
endmodule

// File: rtl/xbar_err_resp.sv
module xbar_err_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pend
);
  timeunit 1ns;
  timeprecision 1ps;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= fire;
  end
endmodule

// File: rtl/burst_xbar.sv
module burst_xbar import xbar_pkg::*; #(
  parameter  int N_INI  = XB_DEF_PORTS,
  parameter  int N_TGT  = XB_DEF_PORTS,
  parameter  int ADDR_W = XB_DEF_ADDR_W,
  parameter  int DATA_W = XB_DEF_DATA_W,
  localparam int IW     = (N_INI > 1) ? $clog2(N_INI) : 1,
  localparam int TW     = (N_TGT > 1) ? $clog2(N_TGT) : 1
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [TW-1:0]           cfg_idx,
  input  logic [ADDR_W-1:0]       cfg_base,
  input  logic [ADDR_W-1:0]       cfg_limit,
  input  logic                    cfg_en,
  input  logic [N_INI-1:0]        i_valid,
  input  logic [N_INI*ADDR_W-1:0] i_addr,
  input  logic [N_INI*DATA_W-1:0] i_wdata,
  input  logic [N_INI-1:0]        i_last,
  output logic [N_INI-1:0]        i_ready,
  output logic [N_INI-1:0]        i_rvalid,
  output logic [N_INI*DATA_W-1:0] i_rdata,
  output logic [N_INI-1:0]        i_rlast,
  output logic [N_INI-1:0]        i_rerr,
  output logic [N_TGT-1:0]        t_valid,
  output logic [N_TGT*ADDR_W-1:0] t_addr,
  output logic [N_TGT*DATA_W-1:0] t_wdata,
  output logic [N_TGT-1:0]        t_last,
  input  logic [N_TGT-1:0]        t_ready,
  input  logic [N_TGT-1:0]        t_rvalid,
  input  logic [N_TGT*DATA_W-1:0] t_rdata,
  input  logic [N_TGT-1:0]        t_rlast
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [N_INI-1:0]          hit_w;
  logic [N_INI-1:0][TW-1:0]  sel_w;
  logic [N_TGT-1:0]          hold_w;
  logic [N_TGT-1:0]          act_w;
  logic [N_TGT-1:0][IW-1:0]  own_w;
  logic [N_INI-1:0]          err_pend;

  xbar_win_table #(
    .N_INI(N_INI), .N_TGT(N_TGT), .ADDR_W(ADDR_W), .TW(TW)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_base (cfg_base),
    .cfg_limit(cfg_limit),
    .cfg_en   (cfg_en),
    .ini_addr (i_addr),
    .hit      (hit_w),
    .sel      (sel_w)
  );

  for (genvar gj = 0; gj < N_TGT; gj++) begin : g_tgt
    logic [N_INI-1:0] want;
    always_comb begin
      for (int k = 0; k < N_INI; k++)
        want[k] = i_valid[k] && hit_w[k] && (sel_w[k] == TW'(gj));
    end

    xbar_tgt_arb #(.N_INI(N_INI), .IW(IW)) u_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (want),
      .done (t_rvalid[gj] && t_rlast[gj]),
      .hold (hold_w[gj]),
      .act  (act_w[gj]),
      .owner(own_w[gj])
    );

    assign t_valid[gj]                    = act_w[gj] && want[own_w[gj]];
    assign t_last[gj]                     = i_last[own_w[gj]];
    assign t_addr[gj*ADDR_W +: ADDR_W]    = i_addr[own_w[gj]*ADDR_W +: ADDR_W];
    assign t_wdata[gj*DATA_W +: DATA_W]   = i_wdata[own_w[gj]*DATA_W +: DATA_W];
  end

  for (genvar gi = 0; gi < N_INI; gi++) begin : g_ini
    logic              rdy;
    logic              rv;
    logic              rl;
    logic              re;
    logic [DATA_W-1:0] rd;

    xbar_err_resp u_err (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (i_valid[gi] && !hit_w[gi] && i_last[gi]),
      .pend (err_pend[gi])
    );

    always_comb begin
      rdy = 1'b0;
      if (i_valid[gi]) begin
        if (!hit_w[gi]) rdy = 1'b1;
        else rdy = act_w[sel_w[gi]] && (own_w[sel_w[gi]] == IW'(gi)) && t_ready[sel_w[gi]];
      end
    end

    always_comb begin
      rv = 1'b0;
      rl = 1'b0;
      re = 1'b0;
      rd = '0;
      for (int j = 0; j < N_TGT; j++) begin
        if (hold_w[j] && (own_w[j] == IW'(gi)) && t_rvalid[j]) begin
          rv = 1'b1;
          rl = t_rlast[j];
          rd = t_rdata[j*DATA_W +: DATA_W];
        end
      end
      if (err_pend[gi]) begin
        rv = 1'b1;
        rl = 1'b1;
        re = 1'b1;
        rd = '0;
      end
    end

    assign i_ready[gi]                  = rdy;
    assign i_rvalid[gi]                 = rv;
    assign i_rlast[gi]                  = rl;
    assign i_rerr[gi]                   = re;
    assign i_rdata[gi*DATA_W +: DATA_W] = rd;
  end
endmodule

// File: rtl/burst_xbar_chk.sv
module burst_xbar_chk #(
  parameter int N_INI = 8,
  parameter int N_TGT = 8,
  parameter int IW    = 3,
  parameter int TW    = 3
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_INI-1:0]         i_valid,
  input logic [N_INI-1:0]         i_ready,
  input logic [N_INI-1:0]         i_last,
  input logic [N_INI-1:0]         i_rvalid,
  input logic [N_INI-1:0]         i_rerr,
  input logic [N_INI-1:0]         i_rlast,
  input logic [N_INI-1:0]         hit_w,
  input logic [N_INI-1:0][TW-1:0] sel_w,
  input logic [N_TGT-1:0]         t_valid,
  input logic [N_TGT-1:0]         t_ready,
  input logic [N_TGT-1:0]         t_rvalid,
  input logic [N_TGT-1:0]         t_rlast,
  input logic [N_TGT-1:0]         hold_w,
  input logic [N_TGT-1:0][IW-1:0] own_w
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar gj = 0; gj < N_TGT; gj++) begin : g_t
    logic [N_INI-1:0] rdy_here;
    always_comb begin
      for (int k = 0; k < N_INI; k++)
        rdy_here[k] = i_ready[k] && hit_w[k] && (sel_w[k] == TW'(gj));
    end

    a_r4_grant_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_w[gj] && !(t_rvalid[gj] && t_rlast[gj])) |=> (hold_w[gj] && $stable(own_w[gj])));

    a_r5_release_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_w[gj] && t_rvalid[gj] && t_rlast[gj]) |=> !hold_w[gj]);

    a_r9_accept_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (t_valid[gj] && t_ready[gj]) |-> i_ready[own_w[gj]]);

    a_r6_one_per_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rdy_here));
  end

  for (genvar gi = 0; gi < N_INI; gi++) begin : g_i
    a_r7_err_accepts: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid[gi] && !hit_w[gi]) |-> i_ready[gi]);

    a_r7_err_reply: assert property (@(posedge clk) disable iff (!rst_n)
      (i_valid[gi] && !hit_w[gi] && i_last[gi]) |=> (i_rvalid[gi] && i_rerr[gi] && i_rlast[gi]));

    a_r9_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      i_ready[gi] |-> i_valid[gi]);
  end
endmodule

bind burst_xbar burst_xbar_chk #(
  .N_INI(N_INI), .N_TGT(N_TGT), .IW(IW), .TW(TW)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .i_valid (i_valid),
  .i_ready (i_ready),
  .i_last  (i_last),
  .i_rvalid(i_rvalid),
  .i_rerr  (i_rerr),
  .i_rlast (i_rlast),
  .hit_w   (hit_w),
  .sel_w   (sel_w),
  .t_valid (t_valid),
  .t_ready (t_ready),
  .t_rvalid(t_rvalid),
  .t_rlast (t_rlast),
  .hold_w  (hold_w),
  .own_w   (own_w)
);

// File: tb/burst_xbar_tb_top.sv
module burst_xbar_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            cfg_we = 1'b0;
  logic [2:0]      cfg_idx = '0;
  logic [AW-1:0]   cfg_base = '0;
  logic [AW-1:0]   cfg_limit = '0;
  logic            cfg_en = 1'b0;
  logic [N-1:0]    b_valid = '0;
  logic [N*AW-1:0] b_addr = '0;
  logic [N*DW-1:0] b_wdata = '0;
  logic [N-1:0]    b_last = '0;
  logic [N-1:0]    i_ready, i_rvalid, i_rlast, i_rerr;
  logic [N*DW-1:0] i_rdata;
  logic [N-1:0]    t_valid, t_last;
  logic [N*AW-1:0] t_addr;
  logic [N*DW-1:0] t_wdata;
  logic [N-1:0]    t_ready = '1;
  logic [N-1:0]    t_rvalid = '0;
  logic [N*DW-1:0] t_rdata = '0;
  logic [N-1:0]    t_rlast = '0;

  burst_xbar dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_base(cfg_base), .cfg_limit(cfg_limit), .cfg_en(cfg_en),
    .i_valid(b_valid), .i_addr(b_addr), .i_wdata(b_wdata), .i_last(b_last),
    .i_ready(i_ready), .i_rvalid(i_rvalid), .i_rdata(i_rdata), .i_rlast(i_rlast), .i_rerr(i_rerr),
    .t_valid(t_valid), .t_addr(t_addr), .t_wdata(t_wdata), .t_last(t_last),
    .t_ready(t_ready), .t_rvalid(t_rvalid), .t_rdata(t_rdata), .t_rlast(t_rlast)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // target model: target 0 stalls every other cycle; response two cycles after the last beat
  int m_cd[N];
  int m_beats[N];
  int m_nb[N];
  int m_src[N];
  int m_order[N][128];
  int m_ocount[N];
  int m_viol = 0;
  int m_total = 0;
  int conc_hits = 0;
  logic m_tog = 1'b0;

  initial begin
    for (int j = 0; j < N; j++) begin
      m_cd[j] = 0; m_beats[j] = 0; m_nb[j] = 0; m_src[j] = 0; m_ocount[j] = 0;
    end
  end

  always begin
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      if (m_cd[j] == 1) begin
        t_rvalid[j] = 1'b1;
        t_rlast[j]  = 1'b1;
        t_rdata[j*DW +: DW] = {4'(j), 4'(m_src[j]), 24'(m_nb[j])};
        m_cd[j] = 0;
      end else begin
        t_rvalid[j] = 1'b0;
        t_rlast[j]  = 1'b0;
        if (m_cd[j] > 1) m_cd[j] = m_cd[j] - 1;
      end
    end
    m_tog = ~m_tog;
    t_ready[0] = m_tog;
    #1;
    if (t_valid == '1) conc_hits++;
    for (int j = 0; j < N; j++) begin
      if (t_valid[j] && t_ready[j]) begin
        m_total++;
        if (m_beats[j] == 0) begin
          m_src[j] = int'(t_wdata[j*DW+28 +: 4]);
          if (m_ocount[j] < 128) m_order[j][m_ocount[j]] = m_src[j];
          m_ocount[j]++;
        end else if (m_src[j] != int'(t_wdata[j*DW+28 +: 4])) m_viol++;
        if (int'(t_wdata[j*DW +: 8]) != m_beats[j]) m_viol++;
        m_beats[j]++;
        if (t_last[j]) begin
          m_nb[j] = m_beats[j];
          m_beats[j] = 0;
          m_cd[j] = 2;
        end
      end
    end
  end

  // window mirror and expected decode
  logic [AW-1:0] mb[N];
  logic [AW-1:0] ml[N];
  logic          me[N];
  int            ptr_exp[N];

  initial begin
    for (int j = 0; j < N; j++) begin mb[j] = '0; ml[j] = '0; me[j] = 1'b0; ptr_exp[j] = 0; end
  end

  function automatic int exp_tgt(input logic [AW-1:0] a);
    for (int j = 0; j < N; j++)
      if (me[j] && a >= mb[j] && a <= ml[j]) return j;
    return -1;
  endfunction

  task automatic cfg_write(input int idx, input logic [AW-1:0] lo, input logic [AW-1:0] hi, input logic on);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_base = lo; cfg_limit = hi; cfg_en = on;
    @(negedge clk);
    cfg_we = 1'b0;
    mb[idx] = lo; ml[idx] = hi; me[idx] = on;
  endtask

  logic [DW-1:0] res_data[N];
  logic          res_err[N];
  logic          res_got[N];

  task automatic txn(input int i, input logic [AW-1:0] a, input int nb);
    int w;
    if (nb == 0) return;
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      b_valid[i] = 1'b1;
      b_addr[i*AW +: AW] = a;
      b_wdata[i*DW +: DW] = {4'(i), 20'd0, 8'(b)};
      b_last[i] = (b == nb - 1);
      w = 0;
      #1;
      while (!i_ready[i] && w < 2000) begin @(negedge clk); #1; w++; end
      @(negedge clk);
    end
    b_valid[i] = 1'b0;
    b_last[i] = 1'b0;
    res_got[i] = 1'b0; res_err[i] = 1'b0; res_data[i] = '0;
    w = 0;
    #1;
    while (w < 2000) begin
      if (i_rvalid[i]) begin
        res_data[i] = i_rdata[i*DW +: DW];
        res_err[i] = i_rerr[i];
        if (i_rlast[i]) begin res_got[i] = 1'b1; break; end
      end
      @(negedge clk); #1; w++;
    end
  endtask

  task automatic judge(input string tag, input int i, input logic [AW-1:0] a, input int nb);
    int e;
    e = exp_tgt(a);
    if (e < 0) chk(tag, {30'd0, res_got[i], res_err[i], res_data[i]}, {30'd0, 1'b1, 1'b1, 32'd0});
    else begin
      chk(tag, {30'd0, res_got[i], res_err[i], res_data[i]}, {30'd0, 1'b1, 1'b0, 4'(e), 4'(i), 24'(nb)});
      ptr_exp[e] = (i + 1) % N;
    end
  endtask

  task automatic single(input string tag, input int i, input logic [AW-1:0] a, input int nb);
    txn(i, a, nb);
    judge(tag, i, a, nb);
  endtask

  logic [AW-1:0] par_addr[N];
  int            par_nb[N];

  task automatic par_run();
    fork
      txn(0, par_addr[0], par_nb[0]);
      txn(1, par_addr[1], par_nb[1]);
      txn(2, par_addr[2], par_nb[2]);
      txn(3, par_addr[3], par_nb[3]);
      txn(4, par_addr[4], par_nb[4]);
      txn(5, par_addr[5], par_nb[5]);
      txn(6, par_addr[6], par_nb[6]);
      txn(7, par_addr[7], par_nb[7]);
    join
  endtask

  int exp_ord[N];
  int exp_n;

  task automatic calc_order(input logic [N-1:0] set, input int start);
    logic [N-1:0] left;
    int cur;
    left = set; cur = start; exp_n = 0;
    while (left != '0) begin
      for (int k = 0; k < N; k++) begin
        int c;
        c = (cur + k) % N;
        if (left[c]) begin
          exp_ord[exp_n] = c; exp_n++; left[c] = 1'b0; cur = (c + 1) % N;
          break;
        end
      end
    end
  endtask

  task automatic contend(input string tag, input logic [N-1:0] set, input int tgt);
    int base;
    base = m_ocount[tgt];
    calc_order(set, ptr_exp[tgt]);
    for (int k = 0; k < N; k++) begin
      par_addr[k] = 32'(tgt * 32'h1000 + 32'h40);
      par_nb[k] = set[k] ? 1 + (k % 3) : 0;
    end
    par_run();
    for (int q = 0; q < exp_n; q++)
      chk($sformatf("%s order slot %0d", tag, q), 64'(m_order[tgt][base + q]), 64'(exp_ord[q]));
    for (int k = 0; k < N; k++)
      if (set[k]) chk($sformatf("%s data ini %0d", tag, k),
                      {31'd0, res_got[k], res_data[k]}, {31'd0, 1'b1, 4'(tgt), 4'(k), 24'(par_nb[k])});
    ptr_exp[tgt] = (exp_ord[exp_n - 1] + 1) % N;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    int tot0;
    int c0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: idle after reset
    chk("R1 idle outputs", {40'd0, i_ready, i_rvalid, t_valid}, 64'd0);

    // R1 / R7: no window enabled yet, request is refused by the error responder
    tot0 = m_total;
    single("R1 unconfigured gives error", 2, 32'h1000, 2);
    chk("R7 error beats not forwarded", 64'(m_total - tot0), 64'd0);

    // windows: j -> [j*0x1000, j*0x1000+0xFFF]; window 2 widened to overlap 0..0x2FFF
    for (int j = 0; j < N; j++) cfg_write(j, 32'(j * 32'h1000), 32'(j * 32'h1000 + 32'hFFF), 1'b1);
    cfg_write(2, 32'h0000, 32'h2FFF, 1'b1);

    // R2 R8 R9: every initiator to every target, varied burst lengths (target 0 stalls)
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        single($sformatf("R8 sweep ini %0d tgt %0d", i, j), i, 32'(j * 32'h1000 + 32'h10 * i + 32'h800), 1 + ((i + j) % 4));
    chk("R4 R9 beats ordered and unmixed", 64'(m_viol), 64'd0);

    // R2: inclusive bounds and lowest-index priority
    single("R2 limit of window 0", 1, 32'h0FFF, 1);
    single("R2 base 0x1000 goes to window 1 not 2", 3, 32'h1000, 1);
    single("R2 limit of window 2", 4, 32'h2FFF, 2);
    single("R2 limit of window 7", 5, 32'h7FFF, 1);
    tot0 = m_total;
    single("R7 above last window", 6, 32'h8000, 3);
    chk("R7 no target beats for 0x8000", 64'(m_total - tot0), 64'd0);

    // R3: disable and move windows
    cfg_write(5, 32'h5000, 32'h5FFF, 1'b0);
    single("R3 disabled window 5 errors", 0, 32'h5004, 1);
    cfg_write(6, 32'h9000, 32'h9FFF, 1'b1);
    single("R3 moved window 6 hits 0x9000", 7, 32'h9000, 2);
    single("R3 old window 6 range errors", 7, 32'h6000, 1);
    cfg_write(5, 32'h5000, 32'h5FFF, 1'b1);
    cfg_write(6, 32'h6000, 32'h6FFF, 1'b1);

    // R5: round robin on target 3
    contend("R5 partial", 8'b0110_0100, 3);
    contend("R5 full", 8'hFF, 3);
    chk("R4 no interleave under contention", 64'(m_viol), 64'd0);

    // R6: all targets at once
    c0 = conc_hits;
    for (int k = 0; k < N; k++) begin
      par_addr[k] = 32'(((k + 1) % N) * 32'h1000 + 32'h100);
      par_nb[k] = 4;
    end
    par_run();
    chk("R6 all targets busy in one cycle", 64'(conc_hits > c0), 64'd1);
    for (int k = 0; k < N; k++) judge($sformatf("R6 parallel ini %0d", k), k, par_addr[k], 4);

    // R7 with a live burst alongside
    tot0 = m_total;
    for (int k = 0; k < N; k++) par_nb[k] = 0;
    par_addr[0] = 32'hF000; par_nb[0] = 3;
    par_addr[1] = 32'h1100; par_nb[1] = 2;
    par_run();
    judge("R7 error beside live burst", 0, par_addr[0], 3);
    judge("R8 live burst beside error", 1, par_addr[1], 2);
    chk("R7 only matched beats reach targets", 64'(m_total - tot0), 64'd2);

    @(negedge clk); #1;
    chk("R9 idle at end", {56'd0, i_ready}, 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule